// File: doc/BRIEF.md
# Producer Port Command and Credit Unit

This block sits behind one producer port of an event-scheduling device. Software writes 128-bit queue elements (QEs) into the port. The unit decodes the command byte, the scheduling-type field and the target queue number of each QE. It then sorts the QE into one of these cases:

- an enqueue to be passed on to the scheduler;
- a bookkeeping command that is simply consumed;
- an interrupt-arm request;
- an illegal element.

Enqueues draw from one of two credit pools, so the on-chip queue storage can never overflow. One pool serves load-balanced queues and the other serves directed queues. Each consumer dequeue sends back a one-cycle return pulse that refunds one credit to the matching pool.

Both the QE input and the accepted-enqueue output are valid/ready streams:

- The output is combinational from the input. `enq_valid` depends only on the QE and on the pool state, never on `enq_ready`.
- A legal enqueue is taken only when the downstream is ready and the selected pool holds a credit. Otherwise `qe_ready` stays low and the QE must be held by the producer.
- Every other kind of element is taken at once.

The port's consumer-queue interrupt fires one time for each arm command, as soon as the queue depth is non-zero.

Top module: `pp_cmd_unit`

## Requirements
- R1: After reset both pools are full (LB_CREDITS load-balanced, DIR_CREDITS directed), the port is disarmed, and `irq` and `err` are low.
- R2: QE bit fields: data [127:64], opaque [63:48], qid [47:40], sched [39:38], priority [37:35], msg_type [34:32], lock_id [31:16], reserved [15:8], cmd [7:0]. An accepted enqueue appears on `enq_qe` bit-for-bit unchanged.
- R3: Command codes are 0x01 new enqueue, 0x02 forward, 0x03 complete, 0x04 token return and 0x05 arm. Sched codes are 0 atomic, 1 unordered, 2 ordered and 3 directed. Codes 0x01 and 0x02 are enqueues. They spend one directed credit when sched is 3 and one load-balanced credit otherwise, and `enq_dir` equals (sched == 3).
- R4: For a legal enqueue, `enq_valid` is high exactly when `qe_valid` is high and the selected pool is non-empty, and `qe_ready` equals `enq_ready` ANDed with the pool being non-empty. With an empty pool the QE is stalled, not dropped.
- R5: Each `lb_ret` / `dir_ret` pulse adds one credit, saturating at the pool size. A spend and a return in the same cycle leave the pool unchanged.
- R6: An element with an undefined cmd code, or an enqueue whose qid is not below the queue count of its kind (NUM_LB_Q or NUM_DIR_Q), is accepted at once without output or credit use. `err` pulses for one cycle in the next cycle.
- R7: Complete and token-return commands are accepted at once with no output, no credit change and no error.
- R8: An accepted arm command arms the port from the next cycle. While armed, a non-zero `cq_depth` raises `irq` for one cycle in the following cycle and disarms the port.
- R9: With the port disarmed, a non-zero or rising `cq_depth` never raises `irq`. A second interrupt needs a new arm command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qe_valid | input | 1 | QE offered by the producer |
| qe_ready | output | 1 | QE taken this cycle |
| qe_bits | input | 128 | Queue element |
| enq_valid | output | 1 | Enqueue offered downstream |
| enq_ready | input | 1 | Downstream accepts enqueue |
| enq_dir | output | 1 | Enqueue is directed (else load-balanced) |
| enq_qe | output | 128 | Enqueued element |
| lb_ret | input | 1 | One load-balanced credit returned |
| dir_ret | input | 1 | One directed credit returned |
| cq_depth | input | DEPTH_W | Current consumer-queue depth |
| err | output | 1 | Illegal element seen (one-cycle pulse) |
| irq | output | 1 | Consumer-queue interrupt (one-cycle pulse) |

## Verification
The bench runs the following patterns against a cycle-level model:

- Enqueues of every sched value. These separate the two pools.
- Bursts that drain each small pool. These show stalling against dropping.
- Downstream back-pressure while credit remains. This separates the ready path from the credit path.
- Surplus returns, and returns that coincide with a spend. These expose bad saturation and bad net-zero arithmetic.
- Undefined codes and out-of-range queue numbers for each kind.
- Depth changes before arming, after arming, and with the depth already non-zero at arm time. These tell a single armed pulse apart from a level interrupt or a missing disarm.

// File: rtl/pp_cmd_pkg.sv
package pp_cmd_pkg;
  localparam int QE_W      = 128;
  localparam int CMD_LSB   = 0;
  localparam int SCHED_LSB = 38;
  localparam int QID_LSB   = 40;
  localparam int QID_W     = 8;

  typedef enum logic [1:0] {
    SCH_ATOMIC = 2'd0,
    SCH_UNORD  = 2'd1,
    SCH_ORDER  = 2'd2,
    SCH_DIRECT = 2'd3
  } sched_e;

  typedef enum logic [7:0] {
    OP_NEW    = 8'h01,
    OP_FWD    = 8'h02,
    OP_DONE   = 8'h03,
    OP_TOKRET = 8'h04,
    OP_ARM    = 8'h05
  } op_e;

  typedef struct packed {
    logic is_enq;
    logic is_dir;
    logic is_arm;
    logic bad;
  } dec_t;
endpackage

// File: rtl/pp_field_decode.sv
module pp_field_decode
  import pp_cmd_pkg::*;
#(
  parameter int NUM_LB_Q  = 32,
  parameter int NUM_DIR_Q = 64
) (
  input  logic [7:0]       cmd,
  input  logic [1:0]       sched,
  input  logic [QID_W-1:0] qid,
  output dec_t             dec
);
  localparam logic [QID_W:0] LB_LIM  = (QID_W+1)'(NUM_LB_Q);
  localparam logic [QID_W:0] DIR_LIM = (QID_W+1)'(NUM_DIR_Q);

  logic enq_code, known, dir, qid_ok;

  always_comb begin
    enq_code = (cmd == OP_NEW) || (cmd == OP_FWD);
    known    = enq_code || (cmd == OP_DONE) || (cmd == OP_TOKRET) || (cmd == OP_ARM);
    dir      = (sched == SCH_DIRECT);
    qid_ok   = dir ? ({1'b0, qid} < DIR_LIM) : ({1'b0, qid} < LB_LIM);
    dec.is_enq = enq_code && qid_ok;
    dec.is_dir = dir;
    dec.is_arm = (cmd == OP_ARM);
    dec.bad    = !known || (enq_code && !qid_ok);
  end
endmodule

// File: rtl/pp_credit_pool.sv
module pp_credit_pool #(
  parameter int MAX = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic has_credit
);
  localparam int CW = $clog2(MAX + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX);

  logic [CW-1:0] count;
  logic          give_eff;

  assign give_eff   = give && ((count != FULL) || take);
  assign has_credit = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= FULL;
    else if (give_eff && !take) count <= count + CW'(1);
    else if (take && !give_eff) count <= count - CW'(1);
  end

  p_spend_has_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> count != '0);
  p_net_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give) |=> $stable(count));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take && count == FULL) |=> count == FULL);
endmodule

// File: rtl/pp_cq_irq.sv
module pp_cq_irq #(
  parameter int DEPTH_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [DEPTH_W-1:0] cq_depth,
  output logic               irq
);
  logic armed, fire;

  assign fire = armed && (cq_depth != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq   <= fire;
      armed <= arm || (armed && !fire);
    end
  end

  p_fire_needs_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cq_depth) != '0);
  p_no_fire_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq);
endmodule

// File: rtl/pp_cmd_unit.sv
module pp_cmd_unit
  import pp_cmd_pkg::*;
#(
  parameter int LB_CREDITS  = 8192,
  parameter int DIR_CREDITS = 2048,
  parameter int NUM_LB_Q    = 32,
  parameter int NUM_DIR_Q   = 64,
  parameter int DEPTH_W     = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qe_valid,
  output logic               qe_ready,
  input  logic [QE_W-1:0]    qe_bits,
  output logic               enq_valid,
  input  logic               enq_ready,
  output logic               enq_dir,
  output logic [QE_W-1:0]    enq_qe,
  input  logic               lb_ret,
  input  logic               dir_ret,
  input  logic [DEPTH_W-1:0] cq_depth,
  output logic               err,
  output logic               irq
);
  localparam int NPOOL = 2;   // index 0 load-balanced, 1 directed

  dec_t             dec;
  logic [NPOOL-1:0] take, give, has;
  logic             credit_ok, xfer;

  pp_field_decode #(.NUM_LB_Q(NUM_LB_Q), .NUM_DIR_Q(NUM_DIR_Q)) u_dec (
    .cmd  (qe_bits[CMD_LSB +: 8]),
    .sched(qe_bits[SCHED_LSB +: 2]),
    .qid  (qe_bits[QID_LSB +: QID_W]),
    .dec  (dec)
  );

  assign give = {dir_ret, lb_ret};

  for (genvar gi = 0; gi < NPOOL; gi++) begin : g_pool
    localparam int SIZE = (gi == 1) ? DIR_CREDITS : LB_CREDITS;
    assign take[gi] = xfer && (dec.is_dir == (gi == 1));
    pp_credit_pool #(.MAX(SIZE)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take[gi]),
      .give      (give[gi]),
      .has_credit(has[gi])
    );
  end

  assign credit_ok = dec.is_dir ? has[1] : has[0];
  assign enq_valid = qe_valid && dec.is_enq && credit_ok;
  assign qe_ready  = dec.is_enq ? (enq_ready && credit_ok) : 1'b1;
  assign xfer      = enq_valid && enq_ready;
  assign enq_dir   = dec.is_dir;
  assign enq_qe    = qe_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= qe_valid && dec.bad;
  end

  pp_cq_irq #(.DEPTH_W(DEPTH_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (qe_valid && dec.is_arm),
    .cq_depth(cq_depth),
    .irq     (irq)
  );

  p_stall_no_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qe_valid && !qe_ready) |-> !(enq_valid && enq_ready));
  p_err_no_spend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qe_valid && dec.bad) |-> (take == '0));
endmodule

// File: tb/pp_cmd_unit_test.sv
`timescale 1ns/1ps
module pp_cmd_unit_test;
  localparam int LBC = 3, DRC = 2, NLQ = 32, NDQ = 64, DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic qe_valid = 1'b0, enq_ready = 1'b0, lb_ret = 1'b0, dir_ret = 1'b0;
  logic [127:0] qe_bits = '0;
  logic [DW-1:0] cq_depth = '0;
  logic qe_ready, enq_valid, enq_dir, err, irq;
  logic [127:0] enq_qe;

  int checks = 0, fails = 0;
  int m_lb, m_dir;
  bit m_armed, m_err, m_irq;

  always #2 clk = ~clk;

  pp_cmd_unit #(.LB_CREDITS(LBC), .DIR_CREDITS(DRC), .NUM_LB_Q(NLQ),
                .NUM_DIR_Q(NDQ), .DEPTH_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .qe_valid(qe_valid), .qe_ready(qe_ready),
    .qe_bits(qe_bits), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_dir(enq_dir), .enq_qe(enq_qe), .lb_ret(lb_ret), .dir_ret(dir_ret),
    .cq_depth(cq_depth), .err(err), .irq(irq));

  function automatic logic [127:0] mk(input logic [7:0] cmd, input logic [1:0] sch,
                                      input logic [7:0] qid, input logic [63:0] d);
    return {d, 16'hA5C3, qid, sch, 3'd5, 3'd2, 16'hBEEF, 8'h00, cmd};
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [127:0] q,
                      input logic rdy, input logic lr, input logic dr, input int dep);
    logic [7:0] cmd; logic [1:0] sch; int qid;
    bit enq, dir, bad, ok, e_valid, e_ready, xfer, fire, arm;
    qe_valid = v; qe_bits = q; enq_ready = rdy; lb_ret = lr; dir_ret = dr;
    cq_depth = DW'(dep);
    #1;
    cmd = q[7:0]; sch = q[39:38]; qid = int'(q[47:40]);
    dir = (sch == 2'd3);
    enq = (cmd == 8'h01 || cmd == 8'h02) && (dir ? qid < NDQ : qid < NLQ);
    bad = !(cmd >= 8'h01 && cmd <= 8'h05) || ((cmd == 8'h01 || cmd == 8'h02) && !enq);
    ok  = dir ? (m_dir > 0) : (m_lb > 0);
    e_valid = v && enq && ok;
    e_ready = enq ? (rdy && ok) : 1'b1;
    chk(tag, "qe_ready", qe_ready, e_ready);
    chk(tag, "enq_valid", enq_valid, e_valid);
    if (e_valid) begin
      chk(tag, "enq_dir (R3)", enq_dir, dir);
      checks++;
      if (enq_qe !== q) begin
        fails++;
        $display("FAIL %s R2 enq_qe actual=%h expected=%h", tag, enq_qe, q);
      end
    end
    chk(tag, "err (R6)", err, m_err);
    chk(tag, "irq (R8)", irq, m_irq);
    @(posedge clk);
    xfer = e_valid && rdy;
    if (lr && !(m_lb == LBC && !(xfer && !dir))) m_lb++;
    if (dr && !(m_dir == DRC && !(xfer && dir))) m_dir++;
    if (xfer && !dir) m_lb--;
    if (xfer && dir) m_dir--;
    m_err = v && bad;
    fire = m_armed && dep != 0;
    arm = v && cmd == 8'h05;
    m_irq = fire;
    m_armed = arm || (m_armed && !fire);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_lb = LBC; m_dir = DRC; m_armed = 0; m_err = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step("R1", 0, '0, 1, 0, 0, 0);
    // R3 load-balanced spends, R2 pass-through
    step("R3", 1, mk(8'h01, 2'd0, 8'd5, 64'h1111), 1, 0, 0, 0);
    step("R3", 1, mk(8'h02, 2'd2, 8'd31, 64'h2222), 1, 0, 0, 0);
    step("R2", 1, mk(8'h01, 2'd1, 8'd0, 64'hDEADBEEF01234567), 1, 0, 0, 0);
    // R4 load-balanced pool dry: stall, then a return frees it
    step("R4", 1, mk(8'h01, 2'd0, 8'd7, 64'h3333), 1, 0, 0, 0);
    step("R4", 1, mk(8'h01, 2'd0, 8'd7, 64'h3333), 1, 1, 0, 0);
    step("R5", 1, mk(8'h01, 2'd0, 8'd7, 64'h3333), 1, 0, 0, 0);
    // R3 directed pool independent of load-balanced
    step("R3", 1, mk(8'h01, 2'd3, 8'd63, 64'h4444), 1, 0, 0, 0);
    step("R3", 1, mk(8'h02, 2'd3, 8'd1, 64'h5555), 1, 0, 0, 0);
    step("R4", 1, mk(8'h01, 2'd3, 8'd2, 64'h6666), 1, 0, 0, 0);
    // R4 downstream back-pressure with credit present
    step("R4", 1, mk(8'h01, 2'd3, 8'd2, 64'h6666), 0, 0, 1, 0);
    step("R4", 1, mk(8'h01, 2'd3, 8'd2, 64'h6666), 0, 0, 0, 0);
    step("R4", 1, mk(8'h01, 2'd3, 8'd2, 64'h6666), 1, 0, 0, 0);
    // R5 saturation: surplus returns, then drain and observe stall
    for (int i = 0; i < 6; i++) step("R5", 0, '0, 1, 1, 1, 0);
    for (int i = 0; i < 4; i++) step("R5", 1, mk(8'h01, 2'd1, 8'd3, 64'(i)), 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5", 1, mk(8'h01, 2'd3, 8'd3, 64'(i)), 1, 0, 0, 0);
    // R5 spend and return together on a pool with one credit
    step("R5", 0, '0, 1, 1, 0, 0);
    step("R5", 1, mk(8'h01, 2'd2, 8'd9, 64'h77), 1, 1, 0, 0);
    step("R5", 1, mk(8'h01, 2'd2, 8'd9, 64'h78), 1, 0, 0, 0);
    step("R5", 1, mk(8'h01, 2'd2, 8'd9, 64'h79), 1, 0, 0, 0);
    // R6 illegal elements
    step("R6", 1, mk(8'h07, 2'd0, 8'd1, 64'h1), 1, 0, 0, 0);
    step("R6", 1, mk(8'h01, 2'd0, 8'd32, 64'h2), 0, 1, 1, 0);
    step("R6", 1, mk(8'h02, 2'd3, 8'd64, 64'h3), 1, 0, 0, 0);
    step("R6", 1, mk(8'h00, 2'd3, 8'd0, 64'h4), 1, 0, 0, 0);
    step("R6", 0, '0, 1, 0, 0, 0);
    // R7 complete and token return
    step("R7", 1, mk(8'h03, 2'd0, 8'd1, 64'h5), 0, 0, 0, 0);
    step("R7", 1, mk(8'h04, 2'd3, 8'd1, 64'h6), 0, 0, 0, 0);
    step("R7", 1, mk(8'h01, 2'd0, 8'd1, 64'h7), 1, 0, 0, 0);
    // R9 depth non-zero while disarmed
    step("R9", 0, '0, 1, 0, 0, 3);
    step("R9", 0, '0, 1, 0, 0, 0);
    step("R9", 0, '0, 1, 0, 0, 5);
    step("R9", 0, '0, 1, 0, 0, 0);
    // R8 arm with empty queue, then depth rises
    step("R8", 1, mk(8'h05, 2'd0, 8'd0, 64'h0), 0, 0, 0, 0);
    step("R8", 0, '0, 1, 0, 0, 0);
    step("R8", 0, '0, 1, 0, 0, 2);
    step("R8", 0, '0, 1, 0, 0, 2);
    step("R9", 0, '0, 1, 0, 0, 0);
    step("R9", 0, '0, 1, 0, 0, 4);
    step("R9", 0, '0, 1, 0, 0, 4);
    // R8 arm while depth already non-zero
    step("R8", 1, mk(8'h05, 2'd0, 8'd0, 64'h0), 0, 0, 0, 4);
    step("R8", 0, '0, 1, 0, 0, 4);
    step("R8", 0, '0, 1, 0, 0, 4);
    step("R9", 0, '0, 1, 0, 0, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule